// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block is the capture engine of one 8-channel logic analyzer bank. On every edge of the bank's sample clock it can store the current 8-bit input sample in an external 32K x 8 sample RAM. The write pointer is fully synchronous and runs freely. It wraps at the end of the memory, so while capture is active the RAM always holds the newest samples. Arming the core does not move the pointer.

A comparator decides when a sample is the trigger. Only the bits selected by an enable mask are compared against a programmed pattern. The comparison is honoured only while the core is armed. When the trigger fires, the core records the RAM address that received the triggering sample. It then stores a programmed number of further samples and stops in a done state, where it waits for the next arm pulse. Host software reads the RAM from the trigger address backwards and forwards to rebuild the waveform around the event.

Top module: `la_capture_core`

## Requirements
- R1: After reset, and while idle, `sram_we` is low. After reset, `sram_addr` and `trig_addr` read 0 and none of `armed`, `triggered`, `done` is high.
- R2: An `arm` pulse sampled while idle or done makes `armed` high from the next cycle. An `arm` pulse while armed or triggered has no effect on state or on the number of samples stored.
- R3: While armed, and while triggered with post-trigger samples still owed, each clock edge produces one write. From the cycle after that edge, `sram_we` is high and `sram_data` equals the sample at that edge. The write address rises by one per write and wraps from 0x7FFF to 0x0000.
- R4: A sample matches when every bit with `trig_enable` = 1 equals the corresponding `trig_pattern` bit. Bits with enable 0 are ignored. An all-zero enable matches the first armed sample.
- R5: A matching sample while idle or done does not set `triggered` and causes no write.
- R6: After the triggering sample, exactly `post_count` further samples are written. `post_count` is taken at the trigger edge. The next edge raises `done` with no write, and no write follows until the next arm. A `post_count` of 0 gives done right after the trigger write.
- R7: `trig_addr` equals the address the triggering sample was written to, and holds until the next trigger or reset.
- R8: A synchronous reset during capture returns the core to idle, drops `sram_we`, and clears the write pointer, so the next capture starts at address 0.
- R9: At most one of `armed`, `triggered`, `done` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start-capture pulse |
| trig_pattern | input | 8 | Value the enabled sample bits must equal |
| trig_enable | input | 8 | Per-bit compare enable |
| post_count | input | 15 | Samples to store after the trigger |
| sample_in | input | 8 | Input channels |
| sram_addr | output | 15 | Sample RAM write address |
| sram_data | output | 8 | Sample RAM write data |
| sram_we | output | 1 | Sample RAM write strobe |
| armed | output | 1 | Waiting for a trigger |
| triggered | output | 1 | Storing post-trigger samples |
| done | output | 1 | Capture complete |
| trig_addr | output | 15 | Address of the triggering sample |

## Verification
The hardest condition to reach is the pointer wrap from 0x7FFF to 0x0000 during an armed capture. The stimulus holds a pattern that can never match and lets the core run armed for more than a full memory's worth of samples. Every write address is compared with a model pointer, and the trigger is then released by clearing the enable mask. An arm pulse is also placed inside the post-trigger window to show that the count is neither restarted nor extended.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/la_pattern_match.sv
module la_pattern_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] enable,
  output logic              hit
);
  logic [DATA_W-1:0] bit_miss;

  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_bit
      // a disabled lane can never report a miss
      assign bit_miss[i] = enable[i] & (sample[i] ^ pattern[i]);
    end
  endgenerate

  assign hit = ~|bit_miss;

  always_comb begin
    if (enable == '0) begin
      a_open_mask_r4 : assert (hit);
    end
  end
endmodule

// File: rtl/la_wrap_counter.sv
module la_wrap_counter #(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [WIDTH-1:0] value
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (inc) value <= value + 1'b1;
  end

  p_wrap_r3 : assert property (@(posedge clk) disable iff (rst)
    (inc && value == TOP) |=> value == '0);
endmodule

// File: rtl/la_capture_fsm.sv
module la_capture_fsm
  import la_cap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              hit,
  input  logic [CNT_W-1:0]  post_count,
  input  logic [ADDR_W-1:0] wr_ptr,
  output cap_state_e        state,
  output logic              cap_en,
  output logic [ADDR_W-1:0] trig_addr
);
  logic [CNT_W-1:0] post_left;

  assign cap_en = (state == ST_ARMED) || (state == ST_POST && post_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      post_left <= '0;
      trig_addr <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (arm) state <= ST_ARMED;
        ST_ARMED: if (hit) begin
          state     <= ST_POST;
          trig_addr <= wr_ptr;
          post_left <= post_count;
        end
        ST_POST: begin
          if (post_left == '0) state <= ST_DONE;
          else                 post_left <= post_left - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_post_dec_r6 : assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST && $past(state == ST_POST) && $past(post_left != '0))
      |-> post_left == $past(post_left) - 1'b1);

  p_trig_hold_r7 : assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST && $past(state == ST_POST)) |-> $stable(trig_addr));

  p_enter_post_r5 : assert property (@(posedge clk) disable iff (rst)
    $past(state != ST_ARMED) && state == ST_POST |-> $past(state == ST_POST));
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
  import la_cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [DATA_W-1:0] trig_pattern,
  input  logic [DATA_W-1:0] trig_enable,
  input  logic [CNT_W-1:0]  post_count,
  input  logic [DATA_W-1:0] sample_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_data,
  output logic              sram_we,
  output logic              armed,
  output logic              triggered,
  output logic              done,
  output logic [ADDR_W-1:0] trig_addr
);
  logic              hit;
  logic              cap_en;
  logic [ADDR_W-1:0] wr_ptr;
  cap_state_e        state;

  la_pattern_match #(.DATA_W(DATA_W)) u_match (
    .sample (sample_in),
    .pattern(trig_pattern),
    .enable (trig_enable),
    .hit    (hit)
  );

  la_wrap_counter #(.WIDTH(ADDR_W)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .inc  (cap_en),
    .value(wr_ptr)
  );

  la_capture_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .hit       (hit),
    .post_count(post_count),
    .wr_ptr    (wr_ptr),
    .state     (state),
    .cap_en    (cap_en),
    .trig_addr (trig_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_we   <= 1'b0;
      sram_addr <= '0;
      sram_data <= '0;
    end else begin
      sram_we <= cap_en;
      if (cap_en) begin
        sram_addr <= wr_ptr;
        sram_data <= sample_in;
      end
    end
  end

  assign armed     = (state == ST_ARMED);
  assign triggered = (state == ST_POST);
  assign done      = (state == ST_DONE);

  p_addr_step_r3 : assert property (@(posedge clk) disable iff (rst)
    (sram_we && $past(sram_we)) |-> sram_addr == $past(sram_addr) + 1'b1);

  p_done_quiet_r6 : assert property (@(posedge clk) disable iff (rst)
    done |-> !sram_we);

  p_status_excl_r9 : assert property (@(posedge clk) disable iff (rst)
    $onehot0({armed, triggered, done}));

  p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (rst)
    (!armed && !triggered && !done && !$past(armed)) |-> !sram_we);
endmodule

// File: tb/sim_la_capture_core.sv
`timescale 1ns/1ps
module sim_la_capture_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic [7:0]  trig_pattern = '0;
  logic [7:0]  trig_enable = '0;
  logic [14:0] post_count = '0;
  logic [7:0]  sample_in = '0;
  logic [14:0] sram_addr;
  logic [7:0]  sram_data;
  logic        sram_we;
  logic        armed, triggered, done;
  logic [14:0] trig_addr;

  int n_vec = 0;
  int n_bad = 0;
  logic [14:0] exp_ptr = '0;
  logic [14:0] rec;

  always #2 clk = ~clk;

  la_capture_core u0 (
    .clk(clk), .rst(rst), .arm(arm), .trig_pattern(trig_pattern),
    .trig_enable(trig_enable), .post_count(post_count), .sample_in(sample_in),
    .sram_addr(sram_addr), .sram_data(sram_data), .sram_we(sram_we),
    .armed(armed), .triggered(triggered), .done(done), .trig_addr(trig_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] s, input logic a, input logic exp_we, input string tag);
    @(negedge clk);
    sample_in = s;
    arm = a;
    @(posedge clk);
    #1;
    arm = 1'b0;
    chk({tag, " we"}, sram_we, exp_we);
    if (exp_we) begin
      chk({tag, " addr"}, sram_addr, exp_ptr);
      chk({tag, " data"}, sram_data, s);
      exp_ptr = exp_ptr + 1'b1;
    end
  endtask

  task automatic st(input string tag, input logic a, input logic t, input logic d);
    chk({tag, " status"}, {armed, triggered, done}, {a, t, d});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    exp_ptr = '0;
    chk("R1 we", sram_we, 0);
    chk("R1 addr", sram_addr, 0);
    chk("R1 trig_addr", trig_addr, 0);
    st("R1", 0, 0, 0);
  endtask

  task automatic t_idle;
    trig_enable = 8'h00;
    repeat (3) cyc(8'h5A, 0, 0, "R5 idle");
    st("R5 idle", 0, 0, 0);
  endtask

  task automatic t_basic;
    trig_pattern = 8'hA5; trig_enable = 8'hFF; post_count = 15'd3;
    cyc(8'h00, 1, 0, "R2 arm");
    st("R2 arm", 1, 0, 0);
    cyc(8'h00, 0, 1, "R3 pre");
    cyc(8'hA4, 0, 1, "R4 near");
    cyc(8'h25, 0, 1, "R4 near");
    st("R4 no match", 1, 0, 0);
    rec = exp_ptr;
    cyc(8'hA5, 0, 1, "R3 trig");
    st("R4 match", 0, 1, 0);
    chk("R7 trig_addr", trig_addr, rec);
    cyc(8'h11, 0, 1, "R6 post");
    cyc(8'h22, 0, 1, "R6 post");
    cyc(8'h33, 0, 1, "R6 post");
    cyc(8'h44, 0, 0, "R6 end");
    st("R6 done", 0, 0, 1);
    cyc(8'hA5, 0, 0, "R5 done");
    cyc(8'hA5, 0, 0, "R5 done");
    st("R5 done", 0, 0, 1);
    chk("R7 held", trig_addr, rec);
  endtask

  task automatic t_mask;
    trig_pattern = 8'h05; trig_enable = 8'h0F; post_count = 15'd1;
    cyc(8'h00, 1, 0, "R2 rearm");
    st("R2 rearm", 1, 0, 0);
    cyc(8'h06, 0, 1, "R4 mask");
    st("R4 mask miss", 1, 0, 0);
    rec = exp_ptr;
    cyc(8'hF5, 0, 1, "R4 mask");
    st("R4 mask hit", 0, 1, 0);
    chk("R7 mask", trig_addr, rec);
    cyc(8'h77, 0, 1, "R6 post1");
    cyc(8'h78, 0, 0, "R6 post1 end");
    st("R6 post1", 0, 0, 1);
  endtask

  task automatic t_zero_en;
    trig_enable = 8'h00; post_count = 15'd2;
    cyc(8'h00, 1, 0, "R2 arm");
    rec = exp_ptr;
    cyc(8'h7E, 0, 1, "R4 open");
    st("R4 open", 0, 1, 0);
    chk("R7 open", trig_addr, rec);
    cyc(8'h01, 0, 1, "R6 post2");
    cyc(8'h02, 0, 1, "R6 post2");
    cyc(8'h03, 0, 0, "R6 post2 end");
    st("R6 post2", 0, 0, 1);
  endtask

  task automatic t_post0;
    trig_pattern = 8'h3C; trig_enable = 8'hFF; post_count = 15'd0;
    cyc(8'h00, 1, 0, "R2 arm");
    cyc(8'h3C, 0, 1, "R6 zero trig");
    cyc(8'h99, 0, 0, "R6 zero end");
    st("R6 zero", 0, 0, 1);
  endtask

  task automatic t_arm_ignored;
    trig_pattern = 8'h81; trig_enable = 8'hFF; post_count = 15'd4;
    cyc(8'h00, 1, 0, "R2 arm");
    cyc(8'h00, 1, 1, "R2 arm while armed");
    st("R2 armed", 1, 0, 0);
    rec = exp_ptr;
    cyc(8'h81, 0, 1, "R2 trig");
    cyc(8'h01, 1, 1, "R2 arm while triggered");
    st("R2 triggered", 0, 1, 0);
    cyc(8'h02, 0, 1, "R6 post4");
    cyc(8'h03, 0, 1, "R6 post4");
    cyc(8'h04, 0, 1, "R6 post4");
    chk("R7 hold in post", trig_addr, rec);
    cyc(8'h05, 0, 0, "R6 post4 end");
    st("R6 post4", 0, 0, 1);
  endtask

  task automatic t_wrap;
    trig_pattern = 8'h00; trig_enable = 8'hFF; post_count = 15'd0;
    cyc(8'h00, 1, 0, "R2 arm");
    for (int i = 0; i < 32770; i++) cyc(8'h01, 0, 1, "R3 wrap");
    st("R3 wrap still armed", 1, 0, 0);
    trig_enable = 8'h00;
    cyc(8'h01, 0, 1, "R3 wrap trig");
    cyc(8'h01, 0, 0, "R6 wrap end");
    st("R6 wrap", 0, 0, 1);
  endtask

  task automatic t_reset_mid;
    trig_pattern = 8'h00; trig_enable = 8'hFF; post_count = 15'd0;
    cyc(8'h00, 1, 0, "R2 arm");
    cyc(8'h10, 0, 1, "R8 pre");
    cyc(8'h11, 0, 1, "R8 pre");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R8 we", sram_we, 0);
    chk("R8 trig_addr", trig_addr, 0);
    st("R8", 0, 0, 0);
    @(negedge clk); rst = 1'b0;
    exp_ptr = '0;
    cyc(8'h00, 1, 0, "R8 arm");
    cyc(8'h12, 0, 1, "R8 restart at 0");
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    t_reset();
    t_idle();
    t_basic();
    t_mask();
    t_zero_en();
    t_post0();
    t_arm_ignored();
    t_wrap();
    t_reset_mid();
    report();
  end
endmodule